// File: doc/BRIEF.md
# Hashed Page Table Entry Encoder

The block builds the two 64-bit words of a hashed page table entry: a first word that carries the abbreviated virtual page number and page flags, and a second word that carries the real page number and a page-size code. A request supplies a virtual address, a physical address and a page-size index. One clock later the block presents both encoded words with a valid pulse. If the selected size is not supported, it presents zeroed words with an error pulse instead.

How each size encodes is set by a small descriptor table with one entry per page-size index. Each entry holds a page shift, a large-page size code and a mask of abbreviated-page-number bits to drop. Software loads the table through a one-entry-per-cycle write port. Six indices exist: 0 is the 4K base size, and 1 to 5 are the larger sizes. A shift of zero marks an entry as unsupported. A separate combinational helper reports whether two first words name the same abbreviated page.

Top module: `hpte_encoder`

## Requirements
- R1: Synchronous reset clears out_valid, out_err, out_v and out_r to zero, and sets every descriptor's shift to 0, so a request of any index made right after reset reports an error.
- R2: A request sampled with in_valid high at a clock edge produces exactly one of out_valid or out_err high for the single following cycle. With no request, both flags are low and out_v and out_r are zero.
- R3: For a supported size, out_v bits 63..7 hold (in_va shifted right by 23, with the descriptor's mask bits cleared), shifted left by 7. out_v bits 6..3 are zero.
- R4: out_v bit 2 (large flag) is 1 for every supported index other than 0 and 0 for index 0. out_v bit 1 (secondary) and bit 0 (entry valid) are always 0.
- R5: For index 0, out_r equals in_pa AND 0x3FFFFFFFFFFFF000, and the descriptor's size code has no effect.
- R6: For indices 1 to 5, out_r equals in_pa with its low `shift` bits cleared, ORed with the size code shifted left by 12.
- R7: A request whose descriptor has shift 0, or whose index is 6 or 7, raises out_err with both words zero. Writes to indices 6 and 7 are ignored.
- R8: A descriptor write takes effect for requests from the next cycle on. A request in the same cycle as a write to its index uses the old descriptor.
- R9: cmp_match is 1 exactly when cmp_a XOR cmp_b has no bit set within 0x3FFFFFFFFFFFFF80. Differences in bits 63..62 and 6..0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 3 | Page-size index being written |
| cfg_shift | input | 6 | Page shift for that size (0 = unsupported) |
| cfg_penc | input | 8 | Size code placed at bit 12 of the second word |
| cfg_mask | input | 64 | Abbreviated-page-number bits to clear |
| in_valid | input | 1 | Request strobe |
| in_va | input | 64 | Virtual address |
| in_pa | input | 64 | Physical address |
| in_psize | input | 3 | Page-size index of the request |
| out_valid | output | 1 | Encoded words valid |
| out_err | output | 1 | Request named an unsupported size |
| out_v | output | 64 | Encoded first word |
| out_r | output | 64 | Encoded second word |
| cmp_a | input | 64 | First word to compare |
| cmp_b | input | 64 | Second word to compare |
| cmp_match | output | 1 | Abbreviated page numbers match |

## Verification
Requests are first made against the unconfigured table, which separates the reset state from the configured encodings. After that, index 0 is given a non-zero size code and one large index a non-zero drop mask. This shows whether the size code wrongly leaks into the base-size word and whether the mask is applied to the right word. Large indices with small and large shifts, all-ones addresses and a write issued in the same cycle as a request to that index check the alignment clearing and the write timing. Compare pairs that differ only inside, only above or only below the compared field show where the compared field begins and ends.

// File: rtl/hpte_pkg.sv
package hpte_pkg;
    localparam int WORD_W    = 64;
    localparam int IDX_W     = 3;
    localparam int SHIFT_W   = 6;
    localparam int PENC_W    = 8;
    localparam int NUM_SIZES = 6;
    localparam int VA_DROP   = 23;
    localparam int AVPN_POS  = 7;
    localparam int LARGE_BIT = 2;
    localparam int PENC_POS  = 12;
    localparam logic [WORD_W-1:0] AVPN_FIELD = 64'h3FFF_FFFF_FFFF_FF80;
    localparam logic [WORD_W-1:0] RPN_FIELD  = 64'h3FFF_FFFF_FFFF_F000;

    typedef struct packed {
        logic [SHIFT_W-1:0] shift;
        logic [PENC_W-1:0]  penc;
        logic [WORD_W-1:0]  mask;
    } desc_t;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [WORD_W-1:0] v;
        logic [WORD_W-1:0] r;
    } out_t;
endpackage

// File: rtl/hpte_desc_table.sv
module hpte_desc_table
    import hpte_pkg::*;
#(
    parameter int NUM = NUM_SIZES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  desc_t            wdesc,
    input  logic [IDX_W-1:0] ridx,
    output desc_t            rdesc
);
    desc_t ent_q [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_ent
        desc_t ent_d;
        always_comb begin
            ent_d = ent_q[g];
            if (we && widx == IDX_W'(g)) begin
                ent_d = wdesc;
            end
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= '0;
            end else begin
                ent_q[g] <= ent_d;
            end
        end
    end

    always_comb begin
        rdesc = '0;
        for (int i = 0; i < NUM; i++) begin
            if (ridx == IDX_W'(i)) begin
                rdesc = ent_q[i];
            end
        end
    end
endmodule

// File: rtl/hpte_word_build.sv
module hpte_word_build
    import hpte_pkg::*;
(
    input  logic [WORD_W-1:0] va,
    input  logic [WORD_W-1:0] pa,
    input  logic [IDX_W-1:0]  psize,
    input  desc_t             desc,
    output logic              supported,
    output logic [WORD_W-1:0] v,
    output logic [WORD_W-1:0] r
);
    logic [WORD_W-1:0] abbrev;
    logic [WORD_W-1:0] keep;
    logic              base;

    always_comb begin
        base      = (psize == '0);
        supported = (desc.shift != '0);
        abbrev    = (va >> VA_DROP) & ~desc.mask;
        v         = abbrev << AVPN_POS;
        if (!base) begin
            v[LARGE_BIT] = 1'b1;
        end
        keep = ~((WORD_W'(1) << desc.shift) - WORD_W'(1));
        if (base) begin
            r = pa & RPN_FIELD;
        end else begin
            r = (pa & keep) | (WORD_W'(desc.penc) << PENC_POS);
        end
    end
endmodule

// File: rtl/hpte_avpn_match.sv
module hpte_avpn_match
    import hpte_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic              match
);
    always_comb begin
        match = ((a ^ b) & AVPN_FIELD) == '0;
    end
endmodule

// File: rtl/hpte_encoder.sv
module hpte_encoder
    import hpte_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [SHIFT_W-1:0] cfg_shift,
    input  logic [PENC_W-1:0] cfg_penc,
    input  logic [WORD_W-1:0] cfg_mask,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_va,
    input  logic [WORD_W-1:0] in_pa,
    input  logic [IDX_W-1:0]  in_psize,
    output logic              out_valid,
    output logic              out_err,
    output logic [WORD_W-1:0] out_v,
    output logic [WORD_W-1:0] out_r,
    input  logic [WORD_W-1:0] cmp_a,
    input  logic [WORD_W-1:0] cmp_b,
    output logic              cmp_match
);
    desc_t             wdesc;
    desc_t             rdesc;
    logic              supported;
    logic [WORD_W-1:0] v_w;
    logic [WORD_W-1:0] r_w;
    out_t              st_d;
    out_t              st_q;

    assign wdesc = '{shift: cfg_shift, penc: cfg_penc, mask: cfg_mask};

    hpte_desc_table #(.NUM(NUM_SIZES)) u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .widx  (cfg_idx),
        .wdesc (wdesc),
        .ridx  (in_psize),
        .rdesc (rdesc)
    );

    hpte_word_build u_build (
        .va        (in_va),
        .pa        (in_pa),
        .psize     (in_psize),
        .desc      (rdesc),
        .supported (supported),
        .v         (v_w),
        .r         (r_w)
    );

    hpte_avpn_match u_match (
        .a     (cmp_a),
        .b     (cmp_b),
        .match (cmp_match)
    );

    always_comb begin
        st_d = '0;
        if (in_valid) begin
            if (supported) begin
                st_d.valid = 1'b1;
                st_d.v     = v_w;
                st_d.r     = r_w;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_err   = st_q.err;
    assign out_v     = st_q.v;
    assign out_r     = st_q.r;
endmodule

// File: rtl/hpte_encoder_chk.sv
module hpte_encoder_chk
    import hpte_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [IDX_W-1:0]  in_psize,
    input logic              out_valid,
    input logic              out_err,
    input logic [WORD_W-1:0] out_v,
    input logic [WORD_W-1:0] out_r,
    input logic [WORD_W-1:0] cmp_a,
    input logic [WORD_W-1:0] cmp_b,
    input logic              cmp_match
);
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid ^ out_err)); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !(out_valid || out_err)); // R2
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_v == '0 && out_r == '0)); // R7
    AST_V_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_v[1:0] == 2'b00 && out_v[6:3] == 4'b0000)); // R4
    AST_LARGE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_psize != '0) |=> (!out_valid || out_v[LARGE_BIT])); // R4
    AST_BASE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_psize == '0) |=> (!out_valid || !out_v[LARGE_BIT])); // R4
    AST_BASE_R: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_psize == '0) |=>
        (!out_valid || (out_r[11:0] == '0 && out_r[63:62] == 2'b00))); // R5
    AST_HIGH_IDX_ERR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && int'(in_psize) >= NUM_SIZES) |=> out_err); // R7
    AST_SELF_MATCH: assert property (@(posedge clk) disable iff (rst)
        (cmp_a == cmp_b) |-> cmp_match); // R9
endmodule

bind hpte_encoder hpte_encoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_psize  (in_psize),
    .out_valid (out_valid),
    .out_err   (out_err),
    .out_v     (out_v),
    .out_r     (out_r),
    .cmp_a     (cmp_a),
    .cmp_b     (cmp_b),
    .cmp_match (cmp_match)
);

// File: tb/hpte_encoder_bench.sv
`timescale 1ns/1ps
module hpte_encoder_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic [5:0]  cfg_shift;
    logic [7:0]  cfg_penc;
    logic [63:0] cfg_mask;
    logic        in_valid;
    logic [63:0] in_va, in_pa;
    logic [2:0]  in_psize;
    logic        out_valid, out_err;
    logic [63:0] out_v, out_r;
    logic [63:0] cmp_a, cmp_b;
    logic        cmp_match;

    int vectors = 0;
    int errors  = 0;

    int          m_shift [8];
    logic [7:0]  m_penc  [8];
    logic [63:0] m_mask  [8];

    bit          e_valid, e_err;
    logic [63:0] e_v, e_r;

    always #2.5 clk = ~clk;

    hpte_encoder u_hpte_encoder (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_shift(cfg_shift), .cfg_penc(cfg_penc), .cfg_mask(cfg_mask),
        .in_valid(in_valid), .in_va(in_va), .in_pa(in_pa), .in_psize(in_psize),
        .out_valid(out_valid), .out_err(out_err), .out_v(out_v), .out_r(out_r),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_match(cmp_match)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic predict(bit iv, logic [63:0] va, logic [63:0] pa, int ps);
        int s;
        e_valid = 0; e_err = 0; e_v = 0; e_r = 0;
        if (iv) begin
            s = (ps < 6) ? m_shift[ps] : 0;
            if (s == 0) begin
                e_err = 1;
            end else begin
                e_valid = 1;
                e_v = ((va >> 23) & ~m_mask[ps]) * 64'd128;
                if (ps != 0) e_v = e_v + 64'd4;
                if (ps == 0) e_r = pa & 64'h3FFF_FFFF_FFFF_F000;
                else e_r = ((pa >> s) << s) | ({56'd0, m_penc[ps]} << 12);
            end
        end
    endtask

    task automatic step(string req, bit we, int widx, int wsh, logic [7:0] wpe,
                        logic [63:0] wmk, bit iv, logic [63:0] va, logic [63:0] pa,
                        int ps);
        @(negedge clk);
        cfg_we = we; cfg_idx = 3'(widx); cfg_shift = 6'(wsh);
        cfg_penc = wpe; cfg_mask = wmk;
        in_valid = iv; in_va = va; in_pa = pa; in_psize = 3'(ps);
        predict(iv, va, pa, ps);
        if (we && widx < 6) begin
            m_shift[widx] = wsh; m_penc[widx] = wpe; m_mask[widx] = wmk;
        end
        @(posedge clk);
        #1;
        cfg_we = 0; in_valid = 0;
        check(req, "out_valid", 64'(out_valid), 64'(e_valid));
        check(req, "out_err", 64'(out_err), 64'(e_err));
        check(req, "out_v", out_v, e_v);
        check(req, "out_r", out_r, e_r);
    endtask

    task automatic cmp(string req, logic [63:0] a, logic [63:0] b, bit exp);
        @(negedge clk);
        cmp_a = a; cmp_b = b;
        #1;
        check(req, "cmp_match", 64'(cmp_match), 64'(exp));
    endtask

    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_shift[i] = 0; m_penc[i] = 0; m_mask[i] = 0;
        end
        rst = 1; cfg_we = 0; cfg_idx = 0; cfg_shift = 0; cfg_penc = 0; cfg_mask = 0;
        in_valid = 0; in_va = 0; in_pa = 0; in_psize = 0; cmp_a = 0; cmp_b = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset out_valid", 64'(out_valid), 64'd0);
        check("R1", "reset out_err", 64'(out_err), 64'd0);
        check("R1", "reset out_v", out_v, 64'd0);
        @(negedge clk);
        rst = 0;
        // R1 / R7: unconfigured table reports errors
        step("R1", 0, 0, 0, 0, 0, 1, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        step("R7", 0, 0, 0, 0, 0, 1, 64'hFFFF_0000_1111_2222, 64'h1, 3);
        // R8: write and request same cycle uses old descriptor
        step("R8", 1, 0, 12, 8'hA5, 64'h0, 1, 64'hDEAD_BEEF_CAFE_F00D, 64'h1234, 0);
        // R5: 4K encoding, size code has no effect
        step("R5", 0, 0, 0, 0, 0, 1, 64'hDEAD_BEEF_CAFE_F00D, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        step("R3", 0, 0, 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_1FFF, 0);
        // R2: idle cycle
        step("R2", 0, 0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF, 0);
        // R6 / R3: 64K with drop mask
        step("R6", 1, 1, 16, 8'h01, 64'h0000_0000_0000_000F, 0, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1);
        step("R3", 0, 0, 0, 0, 0, 1, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0012_3456, 1);
        // R6: 16M and 16G shifts
        step("R6", 1, 4, 24, 8'h00, 64'h0000_0000_0000_0001, 0, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 0, 1, 64'h7777_8888_9999_AAAA, 64'h0000_0123_4567_89AB, 4);
        step("R6", 1, 5, 34, 8'h03, 64'h0000_0000_0000_07FF, 0, 0, 0, 0);
        step("R4", 0, 0, 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 5);
        // R7: writes to index 6 ignored, index 7 unsupported, unwritten index 2
        step("R7", 1, 6, 20, 8'h11, 64'h0, 0, 0, 0, 0);
        step("R7", 0, 0, 0, 0, 0, 1, 64'hFFFF, 64'hFFFF, 6);
        step("R7", 0, 0, 0, 0, 0, 1, 64'hFFFF, 64'hFFFF, 7);
        step("R7", 0, 0, 0, 0, 0, 1, 64'hFFFF, 64'hFFFF, 2);
        // R8: disabling a size by writing shift 0
        step("R8", 1, 1, 0, 8'h00, 64'h0, 1, 64'hABCD_0000_0000_0000, 64'h10000, 1);
        step("R8", 0, 0, 0, 0, 0, 1, 64'hABCD_0000_0000_0000, 64'h10000, 1);
        // R9: compare boundaries
        cmp("R9", 64'h0, 64'h0, 1);
        cmp("R9", 64'h0, 64'h0000_0000_0000_007F, 1);
        cmp("R9", 64'h0, 64'h0000_0000_0000_0080, 0);
        cmp("R9", 64'h0, 64'hC000_0000_0000_0000, 1);
        cmp("R9", 64'h0, 64'h2000_0000_0000_0000, 0);
        cmp("R9", 64'h1234_5678_9ABC_DE80, 64'hD234_5678_9ABC_DEFF, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule